// File: doc/BRIEF.md
# PHY Management Frame Controller

This block lets software or an on-chip sequencer reach the management registers of external Ethernet PHYs over a two-wire serial management bus. Software uses a byte-wide register window. It loads a 5-bit PHY address, a 5-bit register index and, for writes, a 16-bit value. It then sets a command bit in the upper byte of the control word. The controller shifts out a clause-22 frame on the management clock and data pins. When the frame ends it drops its busy flag. A read leaves the returned word in the data register.

An ownership byte selects who may start a frame. When its bit 0 is 1, host commands are accepted. When it is 0, a small request port used by an internal sequencer is accepted instead. A command that cannot be honoured raises a command-error flag and starts no frame. A read in which the PHY does not drive the bus low during turnaround raises a read-error flag.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset the control word reads 0, the ownership byte reads 0, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: A read command emits 32 ones, then start `01`, opcode `10`, the PHY address MSB first and the register index MSB first (46 driven bits). It then samples 16 data bits MSB first.
- R3: A write command emits the same header with opcode `01`, then turnaround `10` and the 16 data bits MSB first, 64 driven bits in all.
- R4: `mdc` has a period of `CLK_DIV` clock cycles. `mdio_o` changes only in the cycle where `mdc` falls, and `mdio_i` is sampled when `mdc` rises.
- R5: Busy (control bit 15, offset 0x511 bit 7) reads 1 from the cycle after a command is accepted until the last bit period of the frame ends.
- R6: After a read without error, the data register (0x514 low byte, 0x515 high byte) holds the 16 bits the PHY returned.
- R7: A host write to 0x511 with both bit 0 (read) and bit 1 (write) set sets command error (bit 14, 0x511 bit 6) and starts no frame.
- R8: A host command issued while busy sets command error and does not disturb the frame in flight.
- R9: A host command issued while the ownership bit (0x517 bit 0) is 0 sets command error and starts no frame.
- R10: If `mdio_i` is 1 at the second turnaround bit of a read, read error (bit 13, 0x511 bit 5) is set and the data register keeps its previous value.
- R11: Both error flags are cleared when the next valid command is accepted.
- R12: While the ownership bit is 0, a pulse on `im_req` starts a frame built from the `im_*` fields. While it is 1, `im_req` is ignored.
- R13: `mdio_oe` is 1 for every bit of a write frame. For reads it is 1 only for the 46 header bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte at `bus_addr` (combinational) |
| im_req | input | 1 | Internal sequencer command pulse |
| im_write | input | 1 | Internal command is a write |
| im_phy | input | 5 | Internal command PHY address |
| im_reg | input | 5 | Internal command register index |
| im_wdata | input | 16 | Internal command write data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with `CLK_DIV` = 4, so one bit takes four cycles and a full frame takes about 260 cycles. At that speed a few dozen random reads and writes fit easily, along with the directed busy collision, ownership and error cases. The register window base stays at its default of 0x510, so the command byte at 0x511 and the ownership byte at 0x517 are exercised at their real offsets. A bench PHY model checks each captured frame bit by bit against a frame computed in the bench.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int FRAME_BITS = 64;
    localparam int HDR_BITS   = 46;
    localparam int TA2_IDX    = 47;
    localparam int DATA_IDX   = 48;

    typedef struct packed {
        logic        write;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t s_q, s_d;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == CW'(HALF - 1));
        if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc      = s_q.mdc;
    assign rise_stb = wrap && !s_q.mdc;
    assign fall_stb = wrap &&  s_q.mdc;
endmodule

// File: rtl/mgmt_mdio_engine.sv
module mgmt_mdio_engine
    import phy_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mgmt_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        rd_err,
    output logic [15:0] rdata
);
    typedef struct packed {
        logic                  busy;
        logic                  run;
        logic                  write;
        logic [5:0]            idx;
        logic [FRAME_BITS-1:0] frame;
        logic                  mdio;
        logic                  oe;
        logic                  done;
        logic                  rd_err;
        logic [15:0]           rdata;
    } eng_t;

    eng_t s_q, s_d;
    logic [5:0] nxt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        nxt      = s_q.idx + 6'd1;
        if (start && !s_q.busy) begin
            s_d.busy   = 1'b1;
            s_d.run    = 1'b0;
            s_d.write  = cmd.write;
            s_d.rd_err = 1'b0;
            s_d.frame  = {32'hFFFF_FFFF, 2'b01,
                          cmd.write ? 2'b01 : 2'b10,
                          cmd.phy, cmd.regad,
                          cmd.write ? 2'b10 : 2'b11,
                          cmd.write ? cmd.wdata : 16'hFFFF};
        end
        if (s_q.busy && fall_stb) begin
            if (!s_q.run) begin
                s_d.run   = 1'b1;
                s_d.idx   = '0;
                s_d.mdio  = s_q.frame[FRAME_BITS-1];
                s_d.frame = s_q.frame << 1;
                s_d.oe    = 1'b1;
            end else if (s_q.idx == 6'(FRAME_BITS - 1)) begin
                s_d.busy = 1'b0;
                s_d.run  = 1'b0;
                s_d.oe   = 1'b0;
                s_d.mdio = 1'b1;
                s_d.done = 1'b1;
            end else begin
                s_d.idx   = nxt;
                s_d.mdio  = s_q.frame[FRAME_BITS-1];
                s_d.frame = s_q.frame << 1;
                s_d.oe    = s_q.write || (nxt < 6'(HDR_BITS));
            end
        end
        if (s_q.run && !s_q.write && rise_stb) begin
            if (s_q.idx == 6'(TA2_IDX) && mdio_i) s_d.rd_err = 1'b1;
            if (s_q.idx >= 6'(DATA_IDX)) s_d.rdata = {s_q.rdata[14:0], mdio_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mdio <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign mdio_o  = s_q.mdio;
    assign mdio_oe = s_q.oe;
    assign done    = s_q.done;
    assign rd_err  = s_q.rd_err;
    assign rdata   = s_q.rdata;
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] BASE   = 12'h510
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              im_req,
    input  logic              im_write,
    input  logic [4:0]        im_phy,
    input  logic [4:0]        im_reg,
    input  logic [15:0]       im_wdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_rd_err,
    input  logic [15:0]       eng_rdata,
    output logic              start,
    output mgmt_cmd_t         cmd,
    output logic              cmd_err
);
    localparam logic [ADDR_W-1:0] A_CTL_LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_CTL_HI = ADDR_W'(BASE + 12'd1);
    localparam logic [ADDR_W-1:0] A_PHY    = ADDR_W'(BASE + 12'd2);
    localparam logic [ADDR_W-1:0] A_REG    = ADDR_W'(BASE + 12'd3);
    localparam logic [ADDR_W-1:0] A_DAT_LO = ADDR_W'(BASE + 12'd4);
    localparam logic [ADDR_W-1:0] A_DAT_HI = ADDR_W'(BASE + 12'd5);
    localparam logic [ADDR_W-1:0] A_OWN    = ADDR_W'(BASE + 12'd7);

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
        logic        owner;
        logic        cmd_err;
        logic        rd_err;
        logic        start;
        mgmt_cmd_t   cmd;
    } reg_t;

    reg_t s_q, s_d;
    logic busy_v, want_rd, want_wr;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        busy_v    = eng_busy || s_q.start;
        want_rd   = bus_wdata[0];
        want_wr   = bus_wdata[1];
        if (eng_done) begin
            s_d.rd_err = eng_rd_err;
            if (!eng_rd_err && !s_q.cmd.write) s_d.data = eng_rdata;
        end
        if (bus_we) begin
            unique case (bus_addr)
                A_PHY:    s_d.phy        = bus_wdata[4:0];
                A_REG:    s_d.regad      = bus_wdata[4:0];
                A_DAT_LO: s_d.data[7:0]  = bus_wdata;
                A_DAT_HI: s_d.data[15:8] = bus_wdata;
                A_OWN:    s_d.owner      = bus_wdata[0];
                A_CTL_HI: begin
                    if (want_rd || want_wr) begin
                        if ((want_rd && want_wr) || busy_v || !s_q.owner) begin
                            s_d.cmd_err = 1'b1;
                        end else begin
                            s_d.start   = 1'b1;
                            s_d.cmd     = '{write: want_wr, phy: s_q.phy,
                                            regad: s_q.regad, wdata: s_q.data};
                            s_d.cmd_err = 1'b0;
                            s_d.rd_err  = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (im_req && !s_q.owner && !busy_v) begin
            s_d.start   = 1'b1;
            s_d.cmd     = '{write: im_write, phy: im_phy,
                            regad: im_reg, wdata: im_wdata};
            s_d.cmd_err = 1'b0;
            s_d.rd_err  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTL_HI: bus_rdata = {eng_busy || s_q.start, s_q.cmd_err, s_q.rd_err, 5'b0};
            A_PHY:    bus_rdata = {3'b0, s_q.phy};
            A_REG:    bus_rdata = {3'b0, s_q.regad};
            A_DAT_LO: bus_rdata = s_q.data[7:0];
            A_DAT_HI: bus_rdata = s_q.data[15:8];
            A_OWN:    bus_rdata = {7'b0, s_q.owner};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign start   = s_q.start;
    assign cmd     = s_q.cmd;
    assign cmd_err = s_q.cmd_err;
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
    import phy_mgmt_pkg::*;
#(
    parameter int          CLK_DIV = 4,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] BASE    = 12'h510
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              im_req,
    input  logic              im_write,
    input  logic [4:0]        im_phy,
    input  logic [4:0]        im_reg,
    input  logic [15:0]       im_wdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic        rise_stb, fall_stb;
    logic        eng_start, eng_busy, eng_done, eng_rd_err, cmd_err;
    logic [15:0] eng_rdata;
    mgmt_cmd_t   eng_cmd;

    mgmt_mdc_gen #(.CLK_DIV(CLK_DIV)) u_gen (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mgmt_regs #(.ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .im_req(im_req), .im_write(im_write), .im_phy(im_phy),
        .im_reg(im_reg), .im_wdata(im_wdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rd_err(eng_rd_err),
        .eng_rdata(eng_rdata),
        .start(eng_start), .cmd(eng_cmd), .cmd_err(cmd_err)
    );

    mgmt_mdio_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .cmd(eng_cmd),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .done(eng_done), .rd_err(eng_rd_err), .rdata(eng_rdata)
    );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic eng_start,
    input logic eng_busy,
    input logic cmd_err
);
    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o)); // R4
    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> eng_busy); // R5
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy); // R8
    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> eng_busy); // R13
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> !eng_start); // R7
endmodule

bind phy_mgmt_ctrl phy_mgmt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .eng_start(eng_start), .eng_busy(eng_busy), .cmd_err(cmd_err)
);

// File: tb/phy_mgmt_ctrl_bench.sv
module phy_mgmt_ctrl_bench;
    localparam int CLK_DIV = 4;
    localparam logic [11:0] A_CTL = 12'h511, A_PHY = 12'h512, A_REG = 12'h513,
                            A_DLO = 12'h514, A_DHI = 12'h515, A_OWN = 12'h517;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic im_req = 1'b0, im_write = 1'b0;
    logic [4:0] im_phy = '0, im_reg = '0;
    logic [15:0] im_wdata = '0;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int checks = 0, fails = 0;
    int rc = 0, oe_cnt = 0;
    bit oe_bad = 0, op_rd = 0, phy_absent = 0, done_flag = 0;
    logic [63:0] cap = '0;
    logic [15:0] rd_val = '0;

    always #4 clk = ~clk;

    phy_mgmt_ctrl #(.CLK_DIV(CLK_DIV)) u_phy_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .im_req(im_req), .im_write(im_write), .im_phy(im_phy),
        .im_reg(im_reg), .im_wdata(im_wdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: captures driven bits, returns data on reads
    always @(posedge mdc) begin
        if ((mdio_oe || rc > 0) && rc < 64) begin
            if (mdio_oe) begin
                cap[63-rc] = mdio_o;
                oe_cnt++;
                if (op_rd && rc >= 46) oe_bad = 1;
            end
            rc++;
        end
    end
    always @(negedge mdc) begin
        if (op_rd && rc == 47)                 mdio_i <= phy_absent;
        else if (op_rd && rc >= 48 && rc < 64) mdio_i <= rd_val[63-rc];
        else                                   mdio_i <= 1'b1;
    end

    function automatic logic [63:0] exp_frame(bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, p, r, 2'b10, d};
    endfunction
    function automatic logic [15:0] phy_val(logic [4:0] p, logic [4:0] r);
        return {p, r, 6'h2A} ^ 16'h5A3C;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask
    task automatic rd(logic [11:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask
    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(A_CTL, s);
            if (!s[7]) break;
        end
    endtask
    task automatic arm(bit is_rd, bit absent, logic [15:0] v);
        rc = 0; oe_cnt = 0; oe_bad = 0; cap = '0;
        op_rd = is_rd; phy_absent = absent; rd_val = v;
    endtask

    task automatic host_op(bit w, logic [4:0] p, logic [4:0] r, logic [15:0] d, bit absent, bit collide);
        logic [7:0] s, lo, hi;
        logic [63:0] e;
        arm(!w, absent, phy_val(p, r));
        wr(A_PHY, {3'b0, p}); wr(A_REG, {3'b0, r});
        if (w) begin wr(A_DLO, d[7:0]); wr(A_DHI, d[15:8]); end
        wr(A_CTL, w ? 8'h02 : 8'h01);
        rd(A_CTL, s);
        check(s[7] == 1'b1, "R5 busy after command", s, 8'h80);
        if (collide) begin
            wr(A_CTL, 8'h02);
            rd(A_CTL, s);
            check(s[6] && s[7], "R8 cmd error while busy", s, 8'hC0);
        end
        wait_idle();
        repeat (2) @(negedge clk);
        e = exp_frame(w, p, r, d);
        if (w) begin
            check(cap == e, "R3 write frame", cap, e);
            check(oe_cnt == 64, "R13 oe over write", oe_cnt, 64);
        end else begin
            check(cap[63:18] == e[63:18], "R2 read header", cap[63:18], e[63:18]);
            check(oe_cnt == 46 && !oe_bad, "R13 oe released on read", oe_cnt, 46);
            rd(A_DLO, lo); rd(A_DHI, hi);
            if (!absent)
                check({hi, lo} == phy_val(p, r), "R6 read data", {hi, lo}, phy_val(p, r));
        end
        rd(A_CTL, s);
        if (absent)
            check(s[5] == 1'b1, "R10 read error flag", s, 8'h20);
        else if (collide)
            check(s == 8'h40, "R8 frame undisturbed, err kept", s, 8'h40);
        else
            check(s == 8'h00, "R11 flags clear after valid op", s, 8'h00);
        op_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] s, lo, hi;
        logic [15:0] keep;
        int t0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1;
        rd(A_CTL, s); check(s == 0, "R1 control at reset", s, 0);
        rd(A_OWN, s); check(s == 0, "R1 owner at reset", s, 0);
        check(!mdio_oe && mdio_o, "R1 pins at reset", {mdio_oe, mdio_o}, 2'b01);

        // R4: MDC period
        @(posedge mdc); t0 = 0;
        fork begin @(posedge mdc); end
             begin forever begin @(posedge clk); t0++; end end join_any
        disable fork;
        check(t0 == CLK_DIV, "R4 mdc period", t0, CLK_DIV);

        // R9: host command without ownership
        arm(1, 0, 0);
        wr(A_CTL, 8'h01);
        repeat (40) @(negedge clk);
        rd(A_CTL, s);
        check(s == 8'h40 && oe_cnt == 0, "R9 no ownership", {s, 8'(oe_cnt)}, 16'h4000);

        // R12: internal master write while owner is 0
        arm(0, 0, 0);
        @(negedge clk); im_req = 1; im_write = 1; im_phy = 5'd2; im_reg = 5'd0; im_wdata = 16'h2100;
        @(negedge clk); im_req = 0;
        wait_idle(); repeat (2) @(negedge clk);
        check(cap == exp_frame(1, 5'd2, 5'd0, 16'h2100), "R12 internal write frame",
              cap, exp_frame(1, 5'd2, 5'd0, 16'h2100));
        rd(A_CTL, s); check(s == 0, "R11 internal accept clears error", s, 0);

        wr(A_OWN, 8'h01);
        arm(0, 0, 0);
        @(negedge clk); im_req = 1;
        @(negedge clk); im_req = 0;
        repeat (40) @(negedge clk);
        rd(A_CTL, s);
        check(s == 0 && oe_cnt == 0, "R12 internal ignored when host owns", s, 0);

        // R7: both command bits
        arm(0, 0, 0);
        wr(A_CTL, 8'h03);
        repeat (40) @(negedge clk);
        rd(A_CTL, s);
        check(s == 8'h40 && oe_cnt == 0, "R7 both bits", s, 8'h40);

        // random traffic (first op also clears the error: R11)
        for (int i = 0; i < 14; i++)
            host_op($urandom_range(0, 1), 5'($urandom), 5'($urandom), 16'($urandom), 0, 0);

        // R8: collision during a read
        host_op(0, 5'd7, 5'd1, 16'h0, 0, 1);

        // R10: PHY absent, data register kept
        rd(A_DLO, lo); rd(A_DHI, hi); keep = {hi, lo};
        host_op(0, 5'd9, 5'd3, 16'h0, 1, 0);
        rd(A_DLO, lo); rd(A_DHI, hi);
        check({hi, lo} == keep, "R10 data kept on read error", {hi, lo}, keep);

        // R11: valid command clears read error
        host_op(1, 5'd9, 5'd3, 16'hBEEF, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule